// File: doc/BRIEF.md
# Pixel A-law Compressor, 12 to 10 Bits

This block sits on a streaming pixel bus and turns 12-bit linear pixel samples into 10-bit piecewise-linear codewords. Each codeword has a short segment tag in its upper bits and a mantissa in its lower bits. Dark values below 256 keep every bit. Brighter values fall into wider segments, and those segments keep progressively fewer low-order bits. Across the full input range the mapping never decreases, so the largest input gives the largest code.

An enable input chooses the mode for each pixel. When enable is low, which is the expected state after reset, the block works as a one-cycle register stage and passes the raw 12-bit sample through unchanged. When enable is high, the 10-bit codeword is placed in the low bits of the 12-bit output and the two upper bits are zero. A flag travels with every output pixel and shows which format it carries. The output is registered, and the valid strobe is delayed by one cycle to line up with the data.

Top module: `pix_alaw_comp`

## Requirements
- R1: While reset is asserted, and until the first valid pixel is taken in, pixValidOut, pixOut and pixCoded are all 0.
- R2: pixValidOut in a given cycle equals pixValidIn from the cycle before. Each accepted pixel produces exactly one output pixel, and pixels leave in the order they arrived.
- R3: With compression on, inputs 0 to 127 give code {3'b000, pixIn[6:0]}.
- R4: With compression on, inputs 128 to 255 give code {3'b001, pixIn[6:0]}.
- R5: With compression on, inputs 256 to 511 give code {3'b010, pixIn[7:1]}. Bit 0 of the input is dropped.
- R6: With compression on, inputs 512 to 1023 give code {3'b011, pixIn[8:2]}.
- R7: With compression on, inputs 1024 to 2047 give code {2'b10, pixIn[9:2]}.
- R8: With compression on, inputs 2048 to 4095 give code {2'b11, pixIn[10:3]}.
- R9: A pixel accepted with compEn low appears on pixOut as the unchanged 12-bit input, with pixCoded at 0. compEn is sampled with each pixel, so the mode can change from one pixel to the next.
- R10: A cycle with pixValidIn low leaves pixOut and pixCoded unchanged, whatever pixIn and compEn hold in that cycle.
- R11: A compressed pixel has pixCoded at 1 and pixOut[11:10] at 0. The code is monotonic in the input, and input 4095 gives code 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| compEn | input | 1 | 1 = compress this pixel, 0 = pass it through |
| pixValidIn | input | 1 | Input pixel strobe |
| pixIn | input | 12 | Linear input sample |
| pixValidOut | output | 1 | Output pixel strobe, one cycle after input |
| pixOut | output | 12 | Codeword in bits 9:0, or the raw sample in bypass |
| pixCoded | output | 1 | 1 when pixOut holds a codeword |

## Verification
The bench steps through every input value with compression on. This exercises each segment edge (127/128, 255/256, 511/512, 1023/1024, 2047/2048, 4095). A design with a wrong segment threshold or a mantissa slice off by one bit would give wrong codes at those edges, and would also break the ordering of the code sequence. Changing compEn between back-to-back pixels checks that the mode is taken with each pixel and not taken late. A design that latched the mode one cycle late would send one pixel in the wrong format. Idle cycles with changing data check that the output holds, so a register that loads on every cycle would show up at once.

// File: rtl/alaw_pkg.sv
package alaw_pkg;

  localparam int PIX_W  = 12;
  localparam int CODE_W = 10;
  localparam int SEG_N  = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture the current pixel
    logic encode;  // compress it (0 = raw passthrough)
  } alaw_strobe_t;

  // smallest input that falls in segment s
  function automatic int segFloor(input int s);
    return (s == 0) ? 0 : (64 << s);
  endfunction

  // number of low input bits discarded in segment s
  function automatic int segDrop(input int s);
    case (s)
      0, 1:    return 0;
      2:       return 1;
      3, 4:    return 2;
      default: return 3;
    endcase
  endfunction

  // width of the segment tag in segment s
  function automatic int segTagW(input int s);
    return (s < 4) ? 3 : 2;
  endfunction

  // value of the segment tag in segment s
  function automatic int segTag(input int s);
    return (s < 4) ? s : s - 2;
  endfunction

endpackage

// File: rtl/alaw_ctrl.sv
module alaw_ctrl
  import alaw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         compEn,
  input  logic         pixValidIn,
  output alaw_strobe_t strobe,
  output logic         pixValidOut
);

  logic validQ;

  always_comb begin
    strobe.load   = pixValidIn;
    strobe.encode = compEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= pixValidIn;
  end

  assign pixValidOut = validQ;

endmodule

// File: rtl/alaw_datapath.sv
module alaw_datapath
  import alaw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  alaw_strobe_t      strobe,
  input  logic [PIX_W-1:0]  pixIn,
  output logic [PIX_W-1:0]  pixOut,
  output logic              pixCoded
);

  localparam int PAD_W = PIX_W - CODE_W;

  logic [SEG_N-1:0]  segHit;
  logic [CODE_W-1:0] segCode [SEG_N];
  logic [CODE_W-1:0] codeSel;
  logic [PIX_W-1:0]  pixNext;
  logic [PIX_W-1:0]  pixQ;
  logic              codedQ;

  // one candidate codeword per segment
  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    localparam int DROP  = segDrop(s);
    localparam int TW    = segTagW(s);
    localparam int MW    = CODE_W - TW;
    localparam int TAG   = segTag(s);
    localparam int FLOOR = segFloor(s);
    assign segHit[s]  = (pixIn >= PIX_W'(FLOOR));
    assign segCode[s] = {TW'(TAG), pixIn[DROP +: MW]};
  end

  // the highest segment whose floor is reached wins
  always_comb begin
    codeSel = segCode[0];
    for (int s = 1; s < SEG_N; s++) begin
      if (segHit[s]) codeSel = segCode[s];
    end
  end

  assign pixNext = strobe.encode ? {{PAD_W{1'b0}}, codeSel} : pixIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixQ   <= '0;
      codedQ <= 1'b0;
    end else if (strobe.load) begin
      pixQ   <= pixNext;
      codedQ <= strobe.encode;
    end
  end

  assign pixOut   = pixQ;
  assign pixCoded = codedQ;

  // R9
  bypass_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.encode) |=> (pixOut == $past(pixIn) && !pixCoded));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(pixOut) && $stable(pixCoded)));

  // R11
  code_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixCoded |-> (pixOut[PIX_W-1:CODE_W] == '0));

  // R5
  seg_lsb_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.encode && pixIn[11:8] == 4'b0001)
      |=> (pixOut[9:7] == 3'b010 && pixOut[6:0] == $past(pixIn[7:1])));

  // R11
  top_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.encode && pixIn == '1) |=> (pixOut == PIX_W'(1023)));

endmodule

// File: rtl/pix_alaw_comp.sv
module pix_alaw_comp
  import alaw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             compEn,
  input  logic             pixValidIn,
  input  logic [PIX_W-1:0] pixIn,
  output logic             pixValidOut,
  output logic [PIX_W-1:0] pixOut,
  output logic             pixCoded
);

  alaw_strobe_t strobe;

  alaw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .compEn     (compEn),
    .pixValidIn (pixValidIn),
    .strobe     (strobe),
    .pixValidOut(pixValidOut)
  );

  alaw_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pixIn   (pixIn),
    .pixOut  (pixOut),
    .pixCoded(pixCoded)
  );

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValidIn |=> pixValidOut);

  // R2
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValidIn |=> !pixValidOut);

endmodule

// File: tb/test_pix_alaw_comp.sv
module test_pix_alaw_comp;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        compEn = 1'b0;
  logic        pixValidIn = 1'b0;
  logic [11:0] pixIn = '0;
  logic        pixValidOut;
  logic [11:0] pixOut;
  logic        pixCoded;

  int checkCount = 0;
  int failCount  = 0;
  bit done = 0;

  typedef struct {
    logic [11:0] expPix;
    logic        expCoded;
    string       tag;
  } sb_item_t;

  sb_item_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_alaw_comp i_pix_alaw_comp (
    .clk        (clk),
    .rstN       (rstN),
    .compEn     (compEn),
    .pixValidIn (pixValidIn),
    .pixIn      (pixIn),
    .pixValidOut(pixValidOut),
    .pixOut     (pixOut),
    .pixCoded   (pixCoded)
  );

  // reference mapping written from the segment ranges
  function automatic logic [11:0] refCode(input int x, input bit en);
    int c;
    if (!en)         c = x;
    else if (x < 256)  c = x;
    else if (x < 512)  c = 256 + (x - 256) / 2;
    else if (x < 1024) c = 384 + (x - 512) / 4;
    else if (x < 2048) c = 512 + (x - 1024) / 4;
    else               c = 768 + (x - 2048) / 8;
    return 12'(c);
  endfunction

  function automatic string refTag(input int x, input bit en);
    if (!en)           return "R9";
    if (x == 4095)     return "R11";
    if (x < 128)       return "R3";
    if (x < 256)       return "R4";
    if (x < 512)       return "R5";
    if (x < 1024)      return "R6";
    if (x < 2048)      return "R7";
    return "R8";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver
  task automatic sendPix(input int x, input bit en);
    sb_item_t it;
    @(negedge clk);
    pixIn      = 12'(x);
    compEn     = en;
    pixValidIn = 1'b1;
    it.expPix   = refCode(x, en);
    it.expCoded = en;
    it.tag      = refTag(x, en);
    sbQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pixValidIn = 1'b0;
      pixIn      = 12'(12'hA5A ^ (i * 37));
      compEn     = i[0];
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (pixValidOut) begin
        if (sbQ.size() == 0) begin
          check(0, "R2", "unexpected output pixel", 1, 0);
        end else begin
          sb_item_t it;
          it = sbQ.pop_front();
          check(pixOut == it.expPix, it.tag, "pixOut", int'(pixOut), int'(it.expPix));
          check(pixCoded == it.expCoded, it.tag, "pixCoded", int'(pixCoded), int'(it.expCoded));
          if (it.expCoded)
            check(pixOut[11:10] == 2'b00, "R11", "pad bits", int'(pixOut[11:10]), 0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    logic [11:0] holdPix;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(pixValidOut == 1'b0, "R1", "pixValidOut in reset", int'(pixValidOut), 0);
    check(pixOut == 12'd0, "R1", "pixOut in reset", int'(pixOut), 0);
    check(pixCoded == 1'b0, "R1", "pixCoded in reset", int'(pixCoded), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pixValidOut == 1'b0 && pixOut == 12'd0, "R1", "after release",
          int'(pixOut), 0);

    // R9: passthrough
    sendPix(4095, 0);
    sendPix(12'hA5C, 0);
    sendPix(1, 0);
    idle(2);

    // R3..R8, R11: full sweep with compression
    for (int x = 0; x < 4096; x++) sendPix(x, 1);
    idle(2);

    // R9: mode changes pixel by pixel around segment edges
    sendPix(127, 1);  sendPix(128, 0);  sendPix(255, 1);  sendPix(256, 0);
    sendPix(511, 1);  sendPix(512, 1);  sendPix(1023, 0); sendPix(1024, 1);
    sendPix(2047, 0); sendPix(2048, 1); sendPix(4095, 0); sendPix(4095, 1);

    // R10: output holds through idle cycles with changing inputs
    sendPix(777, 1);
    holdPix = refCode(777, 1);
    idle(1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pixValidIn = 1'b0;
      pixIn      = 12'(i * 1000 + 5);
      compEn     = i[0];
      @(posedge clk);
      #1;
      check(pixOut == holdPix, "R10", "pixOut held", int'(pixOut), int'(holdPix));
      check(pixCoded == 1'b1, "R10", "pixCoded held", int'(pixCoded), 1);
    end

    idle(3);
    check(sbQ.size() == 0, "R2", "outputs missing", sbQ.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule